// File: doc/BRIEF.md
# Periodic Tick Countdown Timer

This block is a small memory-mapped down-counter that gives an operating-system scheduler its regular heartbeat. Software programs a reload value, enables the counter and optionally the interrupt. The counter then steps down by one on every core clock. Each time it passes from one to zero it raises a sticky expiry flag and, when interrupts are allowed, a one-cycle interrupt request. On the next enabled clock it picks up the reload value again, so expiries repeat with a period of reload + 1 cycles.

Software reaches the block over a plain register bus with address, write data, write strobe, read strobe and read data. The read data is combinational and valid in the same cycle as the read strobe. Reading the status word returns the expiry flag and clears it, which suits polled delay loops and timeouts. Software can also sample or preset the running count at any time. A fixed calibration word is readable so that software can scale its measurements. The asynchronous reset is released in step with the clock inside the block.

Top module: `tick_timer`

## Requirements
- R1: After reset every control bit, the expiry flag, the reload value and the current count read as zero, and the calibration word reads as the `CAL_WORD` parameter.
- R2: Register map by byte address: status at 0x0 (bit 0 count enable, bit 1 interrupt enable, bit 16 expiry flag), reload at 0x4, current count at 0x8, calibration at 0xC. Unused bits and addresses with nonzero low two bits read as zero. Read data is valid in the cycle the read strobe is high.
- R3: While enabled the count falls by exactly one per clock. While disabled it holds. Re-enabling resumes from the held value.
- R4: An enabled count of zero takes the reload value at the next clock, so with reload N (N ≥ 1) expiries come every N + 1 cycles.
- R5: An expiry is an enabled step from one to zero, and it sets the expiry flag.
- R6: A read of the status word returns the flag and clears it afterwards. An expiry in the same cycle as that read leaves the flag set. Writes never change the flag.
- R7: The interrupt output is high for exactly the one cycle after each expiry, and only if interrupt enable was 1 at that expiry.
- R8: With reload 0 the counter rests at zero and produces no further expiries.
- R9: Writes to reload and to the current count keep only bits [23:0]. A current-count write takes priority over counting in that cycle.
- R10: The calibration word is read-only, and writes to 0xC change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register written per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero when no read |
| tick_irq | output | 1 | Interrupt request pulse on expiry |

## Verification
A corrupted count shows at the interrupt output as a pulse that is early, late or missing. It also shows directly in the next read of address 0x8. Errors in the period are caught by counting interrupt pulses over a window of ten periods, so a one-cycle drift appears within that window. A wrong flag rule shows up in the first status read after the event. This includes an expiry lost to a coincident read, a flag that is never cleared, and a flag that re-sets with a zero reload. Ignored writes to the flag and calibration bits are read back straight after the write.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int EN_BIT   = 0;
  localparam int IE_BIT   = 1;
  localparam int FLAG_BIT = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CURR   = 2'd2,
    SEL_CAL    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expiry
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // next-state: a preset wins over counting; zero reloads; one->zero expires
  always_comb begin
    cnt_d  = cnt_q;
    expiry = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (en) begin
      if (cnt_q == ZERO) begin
        cnt_d = reload;
      end else begin
        cnt_d  = cnt_q - ONE;
        expiry = (cnt_q == ONE);
      end
    end
  end

  assign cnt_ce = ld | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: one step down per enabled clock
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt_q > ONE) |=> (cnt_q == CNT_W'($past(cnt_q) - ONE)));

  // R3: disabled count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt_q));

  // R4, R8: zero picks up the reload value (which may itself be zero)
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt_q == ZERO) |=> (cnt_q == $past(reload)));

  // R9: preset takes priority
  a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/tt_regs.sv
module tt_regs import tt_pkg::*; #(
  parameter int               CNT_W    = 24,
  parameter logic [DATA_W-1:0] CAL_WORD = 32'h0000_C350
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expiry,
  output logic              cnt_en,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic [CNT_W-1:0]  reload,
  output logic              irq
);
  reg_sel_e         sel;
  logic             aligned;
  logic             wr_ctrl, wr_reload, wr_curr, rd_ctrl;
  logic             en_q, en_d, ie_q, ie_d, flag_q, flag_d, irq_q, irq_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             ctrl_ce, reload_ce;
  logic             unused_wdata_hi;

  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign wr_ctrl   = bus_we & aligned & (sel == SEL_CTRL);
  assign wr_reload = bus_we & aligned & (sel == SEL_RELOAD);
  assign wr_curr   = bus_we & aligned & (sel == SEL_CURR);
  assign rd_ctrl   = bus_re & aligned & (sel == SEL_CTRL);

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  // next-state
  always_comb begin
    en_d     = bus_wdata[EN_BIT];
    ie_d     = bus_wdata[IE_BIT];
    reload_d = bus_wdata[CNT_W-1:0];
    // a new expiry outranks the clear of a coincident status read
    flag_d   = (flag_q & ~rd_ctrl) | expiry;
    irq_d    = expiry & ie_q;
  end

  assign ctrl_ce   = wr_ctrl;
  assign reload_ce = wr_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_ce) begin
      en_q <= en_d;
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_ce) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_re && aligned) begin
      unique case (sel)
        SEL_CTRL: begin
          bus_rdata[EN_BIT]   = en_q;
          bus_rdata[IE_BIT]   = ie_q;
          bus_rdata[FLAG_BIT] = flag_q;
        end
        SEL_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
        SEL_CURR:   bus_rdata[CNT_W-1:0] = cnt;
        SEL_CAL:    bus_rdata = CAL_WORD;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign cnt_en     = en_q;
  assign cnt_ld     = wr_curr;
  assign cnt_ld_val = bus_wdata[CNT_W-1:0];
  assign reload     = reload_q;
  assign irq        = irq_q;

  // R5: expiry always leaves the flag set
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> flag_q);

  // R6: a status read with no expiry clears the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !expiry) |=> !flag_q);

  // R6: without a read the flag never falls
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_ctrl) |=> flag_q);

  // R7: request only when interrupts were enabled at expiry
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie_q && expiry));

  // R7: single-cycle pulse
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer import tt_pkg::*; #(
  parameter int                CNT_W    = 24,
  parameter logic [DATA_W-1:0] CAL_WORD = 32'h0000_C350
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  logic             rst_sync_n;
  logic             cnt_en, cnt_ld, expiry;
  logic [CNT_W-1:0] cnt_ld_val, reload, cnt;

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tt_regs #(.CNT_W(CNT_W), .CAL_WORD(CAL_WORD)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .cnt        (cnt),
    .expiry     (expiry),
    .cnt_en     (cnt_en),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .reload     (reload),
    .irq        (tick_irq)
  );

  tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (cnt_en),
    .ld     (cnt_ld),
    .ld_val (cnt_ld_val),
    .reload (reload),
    .cnt    (cnt),
    .expiry (expiry)
  );
endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  localparam logic [31:0] CAL = 32'h0000_C350;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int base;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  tick_timer #(.CAL_WORD(CAL)) i_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (bus_re) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read: got %h, expected none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h, expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
    if (tick_irq === 1'b1) irq_cnt++;
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    tick();
    bus_re = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", tag, got, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd(4'h0, 32'h0, "R1 status after reset");
    rd(4'h4, 32'h0, "R1 reload after reset");
    rd(4'h8, 32'h0, "R1 count after reset");
    rd(4'hC, CAL,   "R1 calibration word");
    chk(tick_irq, 0, "R1 irq after reset");

    // R9 preset, R3 freeze while disabled
    wr(4'h4, 32'd5);
    wr(4'h8, 32'd3);
    rd(4'h8, 32'd3, "R9 preset count");
    repeat (3) tick();
    rd(4'h8, 32'd3, "R3 count frozen while disabled");

    // R3 two enabled edges: 3 -> 1
    base = irq_cnt;
    wr(4'h0, 32'h1);
    tick();
    wr(4'h0, 32'h0);
    rd(4'h8, 32'd1, "R3 decrement by one per clock");
    // one more enabled edge: 1 -> 0, expiry with interrupts off
    wr(4'h0, 32'h1);
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0001_0000, "R5 flag set on expiry");
    rd(4'h0, 32'h0, "R6 flag cleared by status read");
    tick();
    chk(irq_cnt - base, 0, "R7 no irq with interrupt enable 0");

    // R4/R7 periodic with interrupts on, reload 5 -> period 6
    wr(4'h0, 32'h3);
    repeat (5) tick();
    chk(tick_irq, 0, "R4 no irq before expiry");
    tick();
    chk(tick_irq, 1, "R7 irq the cycle after expiry");
    tick();
    chk(tick_irq, 0, "R7 irq lasts one cycle");
    base = irq_cnt;
    repeat (60) tick();
    chk(irq_cnt - base, 10, "R4 ten periods of reload+1 cycles");

    // R6 read coincident with expiry keeps the flag
    repeat (4) tick();
    rd(4'h0, 32'h0001_0003, "R6 status read during expiry");
    rd(4'h0, 32'h0001_0003, "R6 coincident expiry not lost");
    rd(4'h0, 32'h0000_0003, "R6 flag cleared after read");

    // R8 zero reload: one last expiry, then rest at zero
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'd2);
    base = irq_cnt;
    wr(4'h0, 32'h3);
    repeat (20) tick();
    chk(irq_cnt - base, 1, "R8 single expiry with zero reload");
    rd(4'h8, 32'h0, "R8 count rests at zero");
    rd(4'h0, 32'h0001_0003, "R8 flag from the last expiry");
    rd(4'h0, 32'h0000_0003, "R8 no further expiry");

    // R6 flag not writable, R2 unused bits, misaligned address
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h0001_0000);
    rd(4'h0, 32'h0, "R6 write cannot set flag");
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, 32'h0000_0002, "R2 unused status bits read zero");
    wr(4'h0, 32'h0);
    rd(4'h1, 32'h0, "R2 misaligned address reads zero");

    // R9 masking of reload and count writes
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, 32'h00FF_FFFF, "R9 reload keeps 24 bits");
    wr(4'h8, 32'hABCD_EF12);
    rd(4'h8, 32'h00CD_EF12, "R9 count keeps 24 bits");

    // R10 calibration is read-only
    wr(4'hC, 32'h0);
    rd(4'hC, CAL, "R10 calibration unchanged by write");

    tick();
    tick();
    finish_run();
  end
endmodule